// File: doc/BRIEF.md
# Edge-Triggered Timer Input Capture

This block records the moment an external event happens. It watches an asynchronous input pin. When the pin makes the transition the configured polarity asks for, the block copies the value of a free-running counter into a holding register. The counter itself lives elsewhere and reaches the block as a plain input bus. The held value is presented as two read-only bytes, so that a byte-wide bus can fetch it.

Each qualifying transition also raises a status flag. That flag drives an interrupt request whenever the locally stored interrupt enable is set. Software clears the flag with a one-cycle strobe. A capture is never blocked by a pending flag: the holding register always reflects the latest event. Reset leaves the holding register alone, so a value captured before a reset can still be read after it.

The pin goes through a synchronizer before edge detection. The latched count therefore trails the real event by a fixed, small number of counts.

Top module: `edge_capture_unit`

## Requirements
- R1: `cap_hi` presents bits 15..8 of the captured value and `cap_lo` presents bits 7..0.
- R2: The stored polarity bit selects the capturing transition: 1 means a low-to-high transition captures, 0 means a high-to-low transition captures. A transition in the other direction changes neither the captured value nor the flag.
- R3: Every qualifying transition sets `cap_flag`.
- R4: `cap_irq` is high exactly when `cap_flag` is high and the stored interrupt enable is 1. The polarity and the enable are loaded from `cfg_rise` and `cfg_irq_en` on a cycle where `cfg_we` is 1.
- R5: A `flag_clr` pulse clears `cap_flag`. If a qualifying transition is latched in the same cycle as the pulse, the flag stays set.
- R6: A qualifying transition overwrites the captured value even while `cap_flag` is already set.
- R7: Reset does not alter the captured value. Reset clears the flag, the stored interrupt enable and the stored polarity (polarity becomes 0, high-to-low).
- R8: With the default two synchronizer stages, the captured value is the `count_i` value present at the third rising clock edge after the pin changes.
- R9: Without a qualifying transition, the captured value holds unchanged.
- R10: After reset is released, edge detection stays disarmed until the synchronizer and the previous-sample register hold post-reset samples. The pin level present at reset release is never taken as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous event input |
| count_i | input | 16 | Free-running counter value |
| cfg_we | input | 1 | Load strobe for polarity and interrupt enable |
| cfg_rise | input | 1 | Polarity to load: 1 rising, 0 falling |
| cfg_irq_en | input | 1 | Interrupt enable to load |
| flag_clr | input | 1 | One-cycle strobe that clears the status flag |
| cap_hi | output | 8 | Upper byte of the captured value |
| cap_lo | output | 8 | Lower byte of the captured value |
| cap_flag | output | 1 | Capture status flag |
| cap_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit counter and a two-stage synchronizer. These values make the three-edge capture latency exact and checkable with a counter that advances every cycle. They also leave the window before arming short enough that a polarity change written just after reset can land inside it. The 16-bit width lets the byte split be checked with distinct high and low patterns, including all-ones and all-zeros counts.

// File: rtl/ecap_pkg.sv
// Package ecap_pkg
// Shared types for the edge capture unit.
// Assumes: polarity encoding 0 = falling, 1 = rising.
package ecap_pkg;

    typedef enum logic {
        POL_FALL = 1'b0,
        POL_RISE = 1'b1
    } edge_pol_e;

    // Settings held by the configuration register.
    typedef struct packed {
        edge_pol_e pol;
        logic      irq_en;
    } ecap_cfg_t;

endpackage

// File: rtl/ecap_sync.sv
// Module ecap_sync
// Brings the asynchronous pin into the clock domain through STAGES flops.
// It also produces an arm signal that rises once every stage, plus the
// edge detector's previous-sample flop, holds a sample taken after reset.
// Assumes: STAGES >= 2; synchronous active-low reset.
module ecap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic armed_o
);
    localparam int VLD_W = STAGES + 1;

    logic [STAGES-1:0] sh_q;
    logic [VLD_W-1:0]  vld_q;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], pin_i};
    end

    // Track how many post-reset samples have entered the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[VLD_W-2:0], 1'b1};
    end

    assign lvl_o   = sh_q[STAGES-1];
    assign armed_o = vld_q[VLD_W-1];
endmodule

// File: rtl/ecap_edge.sv
// Module ecap_edge
// Compares the synchronized level with the previous sample and flags a
// transition in the selected direction.
// Assumes: the input level is already synchronous; armed gates out
// samples left over from reset.
module ecap_edge
    import ecap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl_i,
    input  logic      armed_i,
    input  edge_pol_e pol_i,
    output logic      hit_o
);
    logic prev_q;
    logic rise;
    logic fall;

    // Remember the level seen on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    // Decode the transition direction and qualify it by polarity.
    always_comb begin
        rise  = lvl_i & ~prev_q;
        fall  = ~lvl_i & prev_q;
        hit_o = armed_i & ((pol_i == POL_RISE) ? rise : fall);
    end
endmodule

// File: rtl/ecap_latch.sv
// Module ecap_latch
// Holds the counter value taken at the most recent qualifying transition.
// Assumes: hit is a one-cycle pulse. Deliberately has no reset, so a
// value survives a reset of the rest of the block.
module ecap_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             hit_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] cap_o
);
    logic [CNT_W-1:0] cap_q;

    // Load the counter on every qualifying transition, flag or not.
    always_ff @(posedge clk) begin
        if (hit_i) cap_q <= count_i;
    end

    assign cap_o = cap_q;
endmodule

// File: rtl/ecap_flag.sv
// Module ecap_flag
// Status flag and interrupt gating. A set from a transition outranks
// a clear strobe in the same cycle.
// Assumes: synchronous active-low reset clears the flag.
module ecap_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    // Set on a transition, otherwise clear on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (hit_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    // Request an interrupt only while enabled.
    always_comb begin
        flag_o = flag_q;
        irq_o  = flag_q & irq_en_i;
    end
endmodule

// File: rtl/edge_capture_unit.sv
// Module edge_capture_unit
// Top of the input capture block. Synchronizes the event pin, detects the
// configured transition, latches the counter and drives flag and interrupt.
// Assumes: CNT_W is even (split into two equal halves), SYNC_STAGES >= 2.
module edge_capture_unit
    import ecap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              cfg_we,
    input  logic              cfg_rise,
    input  logic              cfg_irq_en,
    input  logic              flag_clr,
    output logic [CNT_W/2-1:0] cap_hi,
    output logic [CNT_W/2-1:0] cap_lo,
    output logic              cap_flag,
    output logic              cap_irq
);
    localparam int BYTE_W = CNT_W / 2;

    ecap_cfg_t        cfg_q;
    logic             lvl;
    logic             armed;
    logic             hit;
    logic [CNT_W-1:0] cap_val;

    // Configuration register: polarity and interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '{pol: POL_FALL, irq_en: 1'b0};
        else if (cfg_we) cfg_q <= '{pol: edge_pol_e'(cfg_rise), irq_en: cfg_irq_en};
    end

    ecap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (cap_pin),
        .lvl_o   (lvl),
        .armed_o (armed)
    );

    ecap_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl),
        .armed_i (armed),
        .pol_i   (cfg_q.pol),
        .hit_o   (hit)
    );

    ecap_latch #(.CNT_W(CNT_W)) u_latch (
        .clk     (clk),
        .hit_i   (hit),
        .count_i (count_i),
        .cap_o   (cap_val)
    );

    ecap_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit),
        .clr_i    (flag_clr),
        .irq_en_i (cfg_q.irq_en),
        .flag_o   (cap_flag),
        .irq_o    (cap_irq)
    );

    // Present the held value as two bytes.
    always_comb begin
        cap_hi = cap_val[CNT_W-1:BYTE_W];
        cap_lo = cap_val[BYTE_W-1:0];
    end
endmodule

// File: rtl/ecap_chk.sv
// Module ecap_chk
// Property checks for edge_capture_unit, attached by bind below.
module ecap_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hit,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count_i,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag,
    input logic             cap_irq
);
    // R3: a latched transition leaves the flag set
    a_r3_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cap_flag);

    // R5: a clear without a competing transition drops the flag
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !cap_flag);

    // R4: no request without a pending flag
    a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> cap_flag);

    // R8: the held value is the counter seen at the hit edge
    a_r8_value_taken: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cap_val == $past(count_i)));

    // R9: no hit, no change
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(cap_val));

    // R7: reset leaves flag and request low
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!cap_flag && !cap_irq));
endmodule

bind edge_capture_unit ecap_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .flag_clr (flag_clr),
    .count_i  (count_i),
    .cap_val  (cap_val),
    .cap_flag (cap_flag),
    .cap_irq  (cap_irq)
);

// File: tb/tb_edge_capture_unit.sv
module tb_edge_capture_unit;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cap_pin = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic             cfg_we = 1'b0;
    logic             cfg_rise = 1'b0;
    logic             cfg_irq_en = 1'b0;
    logic             flag_clr = 1'b0;
    logic [7:0]       cap_hi;
    logic [7:0]       cap_lo;
    logic             cap_flag;
    logic             cap_irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #5 clk = ~clk;

    edge_capture_unit #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .count_i(count_i),
        .cfg_we(cfg_we), .cfg_rise(cfg_rise), .cfg_irq_en(cfg_irq_en),
        .flag_clr(flag_clr), .cap_hi(cap_hi), .cap_lo(cap_lo),
        .cap_flag(cap_flag), .cap_irq(cap_irq)
    );

    typedef struct packed {
        logic        pol;
        logic        pre;
        logic        post;
        logic [15:0] cnt;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 1'b1, 16'h1234, 1'b1},
        '{1'b1, 1'b1, 1'b0, 16'hBEEF, 1'b0},
        '{1'b0, 1'b1, 1'b0, 16'hA55A, 1'b1},
        '{1'b0, 1'b0, 1'b1, 16'h0F0F, 1'b0},
        '{1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b1},
        '{1'b1, 1'b0, 1'b1, 16'h0000, 1'b1}
    };

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic rise, logic ie);
        cfg_we = 1'b1; cfg_rise = rise; cfg_irq_en = ie;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    function automatic bit qualifies(logic pol, logic old_l, logic new_l);
        return (old_l != new_l) && (new_l == pol);
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_cap;
        bit          cap_known;
        logic [15:0] held;
        cap_known = 0;
        exp_cap = '0;

        // Reset state, pin held high through reset.
        cap_pin = 1'b1;
        tick(3);
        check(cap_flag == 1'b0, "R7 flag in reset", 32'(cap_flag), 0);
        check(cap_irq == 1'b0, "R7 irq in reset", 32'(cap_irq), 0);
        rst_n = 1'b1;
        tick();
        // R10: switch to rising polarity inside the unarmed window
        cfg_write(1'b1, 1'b0);
        tick(4);
        check(cap_flag == 1'b0, "R10 no edge from reset level", 32'(cap_flag), 0);

        // Table walk: R1 R2 R3 R9
        foreach (VECS[i]) begin
            logic old_l;
            cfg_write(VECS[i].pol, 1'b0);
            count_i = ~VECS[i].cnt;
            old_l = cap_pin;
            cap_pin = VECS[i].pre;
            if (qualifies(VECS[i].pol, old_l, VECS[i].pre)) begin
                exp_cap = ~VECS[i].cnt; cap_known = 1;
            end
            tick(5);
            pulse_clr();
            tick();
            count_i = VECS[i].cnt;
            cap_pin = VECS[i].post;
            tick(5);
            check(cap_flag == VECS[i].exp, "R2 R3 flag after transition", 32'(cap_flag), 32'(VECS[i].exp));
            if (VECS[i].exp) begin
                exp_cap = VECS[i].cnt; cap_known = 1;
            end
            if (cap_known) begin
                check(cap_hi == exp_cap[15:8], "R1 high byte", 32'(cap_hi), 32'(exp_cap[15:8]));
                check(cap_lo == exp_cap[7:0], "R1 R9 low byte", 32'(cap_lo), 32'(exp_cap[7:0]));
            end
        end

        // Now polarity is rising, pin high. R4 interrupt gating.
        cfg_write(1'b1, 1'b0);
        pulse_clr();
        cap_pin = 1'b0; tick(4);
        count_i = 16'h4444;
        cap_pin = 1'b1; tick(5);
        check(cap_flag == 1'b1, "R3 flag set", 32'(cap_flag), 1);
        check(cap_irq == 1'b0, "R4 irq masked", 32'(cap_irq), 0);
        cfg_write(1'b1, 1'b1);
        check(cap_irq == 1'b1, "R4 irq enabled", 32'(cap_irq), 1);

        // R6: overwrite while flag is still set
        count_i = 16'h5A5A;
        cap_pin = 1'b0; tick(4);
        cap_pin = 1'b1; tick(5);
        check({cap_hi, cap_lo} == 16'h5A5A, "R6 overwrite with flag set", 32'({cap_hi, cap_lo}), 32'h5A5A);

        // R5: plain clear
        pulse_clr();
        check(cap_flag == 1'b0, "R5 clear", 32'(cap_flag), 0);
        check(cap_irq == 1'b0, "R4 irq follows flag", 32'(cap_irq), 0);

        // R5: clear in the same cycle as the hit; hit lands at edge k+2
        cap_pin = 1'b0; tick(4);
        cap_pin = 1'b1;          // before edge k
        tick();                  // after edge k
        tick();                  // after edge k+1
        flag_clr = 1'b1;         // sampled at edge k+2 with the hit
        tick();
        flag_clr = 1'b0;
        check(cap_flag == 1'b1, "R5 set outranks clear", 32'(cap_flag), 1);

        // R8: latency with a counter advancing every cycle
        pulse_clr();
        cap_pin = 1'b0; tick(4);
        count_i = 16'h0100;
        cap_pin = 1'b1;
        for (int c = 0; c < 6; c++) begin
            tick();
            count_i = count_i + 16'd1;
        end
        check({cap_hi, cap_lo} == 16'h0102, "R8 capture latency", 32'({cap_hi, cap_lo}), 32'h0102);

        // R7: captured value survives reset; enable and polarity cleared
        held = {cap_hi, cap_lo};
        count_i = 16'h7777;
        rst_n = 1'b0; tick(3);
        rst_n = 1'b1; tick();
        check({cap_hi, cap_lo} == held, "R7 value kept through reset", 32'({cap_hi, cap_lo}), 32'(held));
        check(cap_flag == 1'b0, "R7 flag cleared", 32'(cap_flag), 0);
        tick(4);
        // Polarity back to falling: the fall captures, irq stays low.
        count_i = 16'h3C3C;
        cap_pin = 1'b0; tick(5);
        check(cap_flag == 1'b1, "R7 falling polarity after reset", 32'(cap_flag), 1);
        check(cap_irq == 1'b0, "R7 enable cleared by reset", 32'(cap_irq), 0);
        check({cap_hi, cap_lo} == 16'h3C3C, "R2 falling capture", 32'({cap_hi, cap_lo}), 32'h3C3C);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule